// File: doc/BRIEF.md
# Compressed Sample Block Sequencer

This block walks one voice through a stream of compressed audio blocks. Every block covers eight address units (sixteen bytes) and decodes to 28 samples. A pitch-driven phase accumulator sets how quickly samples are used. When the last sample of a block has been used, the sequencer reads that block's flag byte from memory. The flag byte then sets the next block address. It can mark a loop point, end the sample, or send playback back to the loop point.

Software writes the pitch, the start address and the loop address. It then starts the voice with a key-on pulse. Each `tick` asks for one output sample's worth of phase advance. The sequencer raises `mem_req` with the block address on `mem_addr` and waits for `mem_rvalid` with the flag byte. It reports the voice state on `voice_active`, `releasing` and `end_flag`. It pulses `irq` when a programmed address falls in a block that matters. Sample decoding and the envelope are handled elsewhere.

The controller has three states. In IDLE the voice is silent. In RUN the phase advances and samples are used. In FETCH a flag-byte read is outstanding. The transitions are:
- key-on from any state goes to FETCH;
- RUN goes to FETCH at a block boundary;
- RUN goes to IDLE at a block boundary when the voice is finishing;
- FETCH goes to RUN when the read data returns.

Top module: `blk_seq_voice`

## Requirements
- R1: After reset, `voice_active`, `mem_req`, `releasing`, `end_flag` and `irq` are all 0.
- R2: A key-on pulse loads the current block address from the start address. `mem_req` is then high on the following cycle, with `mem_addr` equal to that start address.
- R3: Each tick adds the pitch value shifted left by 4 bits to the phase. The step is never smaller than 1. One sample is used for each 0x10000 of phase. A block holds 28 samples, so with pitch 0x1000 there are 28 ticks between two block fetches.
- R4: A pitch write above 0x3FFF stores 0x3FFF. With pitch 0x4000 written, a block takes 8 ticks.
- R5: When bit 0 of the flag byte is clear, the next block address is the current block address plus 8.
- R6: When flag bit 2 is set, the current block address becomes the loop address. This happens only if software has not written the loop address since reset. A written loop address is never replaced.
- R7: A flag byte of exactly 0x03 sets `end_flag`, and the next block address becomes the loop address.
- R8: Any other flag byte with bit 0 set also sets `end_flag`, and it raises `releasing`. The voice uses the 28 samples of the current block. It then goes inactive without another fetch. This applies to 0x07 as well.
- R9: A key-off pulse raises `releasing`, and block fetches continue.
- R10: `end_flag` is cleared by an `end_clr` pulse and by key-on. If a fetch sets the flag in the same cycle as an `end_clr` pulse, the flag is set.
- R11: When `irq_en` is high, `irq` pulses for one cycle after the flag data arrives in either of two cases. The first case is that `irq_addr` lies in the range [block, block+8) of the fetched block. The second is that flag bit 0 is set and `irq_addr` lies in the same range of the loop block.
- R12: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr`, `sample_idx` and the rest of the voice state hold.
- R13: Addresses are 22 bits wide. `addr_sel` picks which half is written:

| `addr_sel` | Half written |
|------------|--------------|
| 0 | start address, low 16 bits |
| 1 | start address, high 6 bits |
| 2 | loop address, low 16 bits |
| 3 | loop address, high 6 bits |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pitch_we | input | 1 | Pitch write strobe |
| pitch_wdata | input | 16 | Pitch value (clamped to 0x3FFF) |
| addr_we | input | 1 | Address half write strobe |
| addr_sel | input | 2 | Selects the address half written (see R13) |
| addr_wdata | input | 16 | Address half value |
| key_on | input | 1 | Start the voice |
| key_off | input | 1 | Request release |
| tick | input | 1 | One output-sample phase advance |
| irq_en | input | 1 | Interrupt enable |
| irq_addr | input | 22 | Interrupt watch address |
| end_clr | input | 1 | Clears the end flag |
| mem_req | output | 1 | Flag-byte read request (valid) |
| mem_addr | output | 22 | Current block address |
| mem_rvalid | input | 1 | Read data valid (ready) |
| mem_rdata | input | 8 | Flag byte |
| voice_active | output | 1 | Voice is not idle |
| releasing | output | 1 | Voice is in release |
| end_flag | output | 1 | End bit of the voice |
| irq | output | 1 | One-cycle interrupt pulse |
| sample_idx | output | 5 | Index of the next sample in the block (28 = block used up) |

## Verification
The end bit can be set and cleared in the same cycle. A returning flag byte with bit 0 set can coincide with a software clear pulse. To provoke this, the bench asserts `end_clr` in the same cycle as `mem_rvalid`, with flag byte 0x01. The check passes when `end_flag` reads 1 on the following cycle. In a separate test, a clear pulse on its own must drive `end_flag` to 0.

// File: rtl/blk_seq_pkg.sv
package blk_seq_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RUN,
        ST_FETCH
    } seq_state_t;

    localparam int          FLG_END_BIT  = 0;
    localparam int          FLG_MARK_BIT = 2;
    localparam logic [7:0]  FLG_LOOP_VAL = 8'h03;
endpackage

// File: rtl/blk_phase.sv
module blk_phase #(
    parameter int PITCH_W = 14,
    parameter int FRAC_W  = 16,
    parameter int SAMPLES = 28
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             load,
    input  logic                             live,
    input  logic                             run_en,
    input  logic                             fetch_done,
    input  logic                             tick,
    input  logic [PITCH_W+3:0]               step,
    output logic                             need_fetch,
    output logic [$clog2(SAMPLES+1)-1:0]     sample_idx
);
    localparam int STEP_W = PITCH_W + 4;
    localparam int PH_W   = STEP_W + 1;
    localparam int IDX_W  = $clog2(SAMPLES + 1);
    localparam logic [PH_W-1:0]  ONE  = PH_W'(1) << FRAC_W;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(SAMPLES);

    logic [PH_W-1:0]  phase_q;
    logic [IDX_W-1:0] idx_q;
    logic             pend_q;
    logic             have;

    assign have       = phase_q >= ONE;
    assign need_fetch = have && (idx_q == LAST);
    assign sample_idx = idx_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
            idx_q   <= '0;
            pend_q  <= 1'b0;
        end else if (load) begin
            phase_q <= ONE;
            idx_q   <= LAST;
            pend_q  <= 1'b0;
        end else if (!live) begin
            pend_q  <= 1'b0;
        end else if (fetch_done) begin
            phase_q <= phase_q - ONE;
            idx_q   <= IDX_W'(1);
            pend_q  <= pend_q | tick;
        end else if (run_en && have) begin
            if (idx_q != LAST) begin
                idx_q   <= idx_q + IDX_W'(1);
                phase_q <= phase_q - ONE;
            end
            pend_q <= pend_q | tick;
        end else if (run_en && (tick || pend_q)) begin
            phase_q <= phase_q + {1'b0, step};
            pend_q  <= 1'b0;
        end else begin
            pend_q  <= pend_q | tick;
        end
    end

    // R3
    idx_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST);

    // R3
    phase_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && have && idx_q != LAST && !load && !fetch_done) |=> (idx_q == $past(idx_q) + IDX_W'(1)));
endmodule

// File: rtl/blk_flag_eval.sv
module blk_flag_eval
    import blk_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int SPAN   = 8
) (
    input  logic [ADDR_W-1:0] cur_addr,
    input  logic [ADDR_W-1:0] loop_addr,
    input  logic [7:0]        flag,
    input  logic              loop_locked,
    input  logic              irq_en,
    input  logic [ADDR_W-1:0] irq_addr,
    output logic [ADDR_W-1:0] next_addr,
    output logic              take_mark,
    output logic              stop,
    output logic              set_end,
    output logic              irq_hit
);
    function automatic logic in_block(input logic [ADDR_W-1:0] a, input logic [ADDR_W-1:0] base);
        logic [ADDR_W-1:0] d;
        d = a - base;
        return (a >= base) && (d < ADDR_W'(SPAN));
    endfunction

    logic is_end;
    logic is_loop;

    always_comb begin
        is_end    = flag[FLG_END_BIT];
        is_loop   = (flag == FLG_LOOP_VAL);
        take_mark = flag[FLG_MARK_BIT] && !loop_locked;
        set_end   = is_end;
        stop      = is_end && !is_loop;
        next_addr = is_loop ? loop_addr : cur_addr + ADDR_W'(SPAN);
        irq_hit   = irq_en && (in_block(irq_addr, cur_addr) ||
                               (is_end && in_block(irq_addr, loop_addr)));
    end
endmodule

// File: rtl/blk_seq_voice.sv
module blk_seq_voice
    import blk_seq_pkg::*;
#(
    parameter int ADDR_W  = 22,
    parameter int LO_W    = 16,
    parameter int PITCH_W = 14,
    parameter int FRAC_W  = 16,
    parameter int SAMPLES = 28,
    parameter int SPAN    = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          pitch_we,
    input  logic [15:0]                   pitch_wdata,
    input  logic                          addr_we,
    input  logic [1:0]                    addr_sel,
    input  logic [LO_W-1:0]               addr_wdata,
    input  logic                          key_on,
    input  logic                          key_off,
    input  logic                          tick,
    input  logic                          irq_en,
    input  logic [ADDR_W-1:0]             irq_addr,
    input  logic                          end_clr,
    output logic                          mem_req,
    output logic [ADDR_W-1:0]             mem_addr,
    input  logic                          mem_rvalid,
    input  logic [7:0]                    mem_rdata,
    output logic                          voice_active,
    output logic                          releasing,
    output logic                          end_flag,
    output logic                          irq,
    output logic [$clog2(SAMPLES+1)-1:0]  sample_idx
);
    localparam int HI_W   = ADDR_W - LO_W;
    localparam int STEP_W = PITCH_W + 4;
    localparam logic [PITCH_W-1:0] PITCH_MAX = {PITCH_W{1'b1}};

    seq_state_t        state_q, state_d;
    logic [PITCH_W-1:0] pitch_q;
    logic [ADDR_W-1:0] start_q, loop_q, cur_q;
    logic              locked_q, final_q, rel_q, end_q, irq_q;
    logic [STEP_W-1:0] step;
    logic              need_fetch, fetch_done, run_en, live;
    logic [ADDR_W-1:0] next_addr;
    logic              take_mark, stop, set_end, irq_hit;

    assign step       = (pitch_q == '0) ? STEP_W'(1) : {pitch_q, 4'b0000};
    assign live       = (state_q != ST_IDLE);
    assign run_en     = (state_q == ST_RUN) && !key_on;
    assign fetch_done = (state_q == ST_FETCH) && mem_rvalid && !key_on;

    blk_phase #(.PITCH_W(PITCH_W), .FRAC_W(FRAC_W), .SAMPLES(SAMPLES)) u_phase (
        .clk(clk), .rst_n(rst_n), .load(key_on), .live(live), .run_en(run_en),
        .fetch_done(fetch_done), .tick(tick), .step(step),
        .need_fetch(need_fetch), .sample_idx(sample_idx)
    );

    blk_flag_eval #(.ADDR_W(ADDR_W), .SPAN(SPAN)) u_eval (
        .cur_addr(cur_q), .loop_addr(loop_q), .flag(mem_rdata), .loop_locked(locked_q),
        .irq_en(irq_en), .irq_addr(irq_addr), .next_addr(next_addr),
        .take_mark(take_mark), .stop(stop), .set_end(set_end), .irq_hit(irq_hit)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (key_on) begin
            state_d = ST_FETCH;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_d = ST_IDLE;
                ST_RUN:   if (need_fetch) state_d = final_q ? ST_IDLE : ST_FETCH;
                ST_FETCH: if (mem_rvalid) state_d = ST_RUN;
                default:  state_d = ST_IDLE;
            endcase
        end
    end

    // data and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pitch_q  <= '0;
            start_q  <= '0;
            loop_q   <= '0;
            cur_q    <= '0;
            locked_q <= 1'b0;
            final_q  <= 1'b0;
            rel_q    <= 1'b0;
            end_q    <= 1'b0;
            irq_q    <= 1'b0;
        end else begin
            if (pitch_we)
                pitch_q <= (pitch_wdata > 16'(PITCH_MAX)) ? PITCH_MAX : pitch_wdata[PITCH_W-1:0];
            if (addr_we) begin
                unique case (addr_sel)
                    2'd0: start_q[LO_W-1:0]      <= addr_wdata;
                    2'd1: start_q[ADDR_W-1:LO_W] <= addr_wdata[HI_W-1:0];
                    2'd2: loop_q[LO_W-1:0]       <= addr_wdata;
                    2'd3: loop_q[ADDR_W-1:LO_W]  <= addr_wdata[HI_W-1:0];
                    default: ;
                endcase
                if (addr_sel[1]) locked_q <= 1'b1;
            end
            irq_q <= fetch_done && irq_hit;
            if (key_on) begin
                cur_q   <= start_q;
                final_q <= 1'b0;
                rel_q   <= 1'b0;
                end_q   <= 1'b0;
            end else begin
                if (fetch_done) begin
                    cur_q <= next_addr;
                    if (take_mark && !(addr_we && addr_sel[1])) loop_q <= cur_q;
                    if (stop) begin
                        final_q <= 1'b1;
                        rel_q   <= 1'b1;
                    end
                end
                if (key_off && live) rel_q <= 1'b1;
                if (fetch_done && set_end) end_q <= 1'b1;
                else if (end_clr)          end_q <= 1'b0;
            end
        end
    end

    assign mem_req      = (state_q == ST_FETCH);
    assign mem_addr     = cur_q;
    assign voice_active = live;
    assign releasing    = rel_q;
    assign end_flag     = end_q;
    assign irq          = irq_q;

    // R12
    fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_rvalid && !key_on) |=> (mem_req && $stable(mem_addr) && $stable(sample_idx)));

    // R11
    irq_after_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(mem_req && mem_rvalid));

    // R10
    end_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(end_flag) |-> $past(mem_req && mem_rvalid));

    // R9
    rel_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(releasing) |-> $past(key_off || (mem_req && mem_rvalid)));
endmodule

// File: tb/test_blk_seq_voice.sv
module test_blk_seq_voice;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pitch_we = 1'b0;
    logic [15:0] pitch_wdata = '0;
    logic        addr_we = 1'b0;
    logic [1:0]  addr_sel = '0;
    logic [15:0] addr_wdata = '0;
    logic        key_on = 1'b0, key_off = 1'b0, tick = 1'b0;
    logic        irq_en = 1'b0;
    logic [21:0] irq_addr = '0;
    logic        end_clr = 1'b0;
    logic        mem_req;
    logic [21:0] mem_addr;
    logic        mem_rvalid = 1'b0;
    logic [7:0]  mem_rdata = '0;
    logic        voice_active, releasing, end_flag, irq;
    logic [4:0]  sample_idx;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blk_seq_voice i_blk_seq_voice (
        .clk(clk), .rst_n(rst_n), .pitch_we(pitch_we), .pitch_wdata(pitch_wdata),
        .addr_we(addr_we), .addr_sel(addr_sel), .addr_wdata(addr_wdata),
        .key_on(key_on), .key_off(key_off), .tick(tick), .irq_en(irq_en),
        .irq_addr(irq_addr), .end_clr(end_clr), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .voice_active(voice_active),
        .releasing(releasing), .end_flag(end_flag), .irq(irq), .sample_idx(sample_idx)
    );

    // {flag, expected fetch address, expected end, releasing, irq}
    localparam logic [32:0] VEC [6] = '{
        {8'h00, 22'h000100, 1'b0, 1'b0, 1'b0},
        {8'h04, 22'h000108, 1'b0, 1'b0, 1'b1},
        {8'h02, 22'h000110, 1'b0, 1'b0, 1'b0},
        {8'h03, 22'h000118, 1'b1, 1'b0, 1'b1},
        {8'h00, 22'h000108, 1'b1, 1'b0, 1'b1},
        {8'h01, 22'h000110, 1'b1, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr_addr(input logic [1:0] sel, input logic [15:0] val);
        addr_we = 1'b1; addr_sel = sel; addr_wdata = val;
        @(negedge clk);
        addr_we = 1'b0;
    endtask

    task automatic wr_pitch(input logic [15:0] val);
        pitch_we = 1'b1; pitch_wdata = val;
        @(negedge clk);
        pitch_we = 1'b0;
    endtask

    task automatic do_key_on();
        key_on = 1'b1;
        @(negedge clk);
        key_on = 1'b0;
    endtask

    task automatic respond(input logic [7:0] flag, input logic clr);
        mem_rdata = flag; mem_rvalid = 1'b1; end_clr = clr;
        @(negedge clk);
        mem_rvalid = 1'b0; end_clr = 1'b0;
    endtask

    task automatic run_ticks(input int n);
        for (int k = 0; k < n; k++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            repeat (6) @(negedge clk);
        end
    endtask

    task automatic run_to_fetch(output int n);
        n = 0;
        while (!mem_req && n < 60) begin
            run_ticks(1);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual 0x1 expected 0x0");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int n;
        logic [32:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 active", voice_active, 0);
        chk("R1 mem_req", mem_req, 0);
        chk("R1 releasing", releasing, 0);
        chk("R1 end_flag", end_flag, 0);
        chk("R1 irq", irq, 0);

        wr_addr(2'd0, 16'h0100);
        wr_addr(2'd1, 16'h0000);
        wr_pitch(16'h1000);
        irq_en = 1'b1; irq_addr = 22'h00010C;
        do_key_on();
        // R2
        chk("R2 req after key-on", mem_req, 1);

        // table walk: R3 R5 R6 R7 R8 R11
        for (int i = 0; i < 6; i++) begin
            v = VEC[i];
            if (i > 0) begin
                run_to_fetch(n);
                chk("R3 ticks per block", n, 28);
            end
            chk("R5 fetch address", mem_addr, int'(v[24:3]));
            respond(v[32:25], 1'b0);
            chk("R7 end flag", end_flag, int'(v[2]));
            chk("R8 releasing", releasing, int'(v[1]));
            chk("R11 irq", irq, int'(v[0]));
        end
        @(negedge clk);
        chk("R11 irq one cycle", irq, 0);

        // R8: finish the block then stop without fetch
        run_ticks(27);
        chk("R8 still active", voice_active, 1);
        run_ticks(1);
        chk("R8 inactive", voice_active, 0);
        chk("R8 no fetch", mem_req, 0);

        // R10 clear pulse
        end_clr = 1'b1;
        @(negedge clk);
        end_clr = 1'b0;
        chk("R10 end_clr", end_flag, 0);

        // R10 set beats clear in same cycle
        do_key_on();
        respond(8'h01, 1'b1);
        chk("R10 set wins", end_flag, 1);
        do_key_on();
        chk("R10 key-on clears", end_flag, 0);

        // R12 hold while waiting for data
        repeat (10) @(negedge clk);
        chk("R12 req held", mem_req, 1);
        chk("R12 addr held", mem_addr, 22'h000100);
        chk("R12 idx held", sample_idx, 28);
        respond(8'h07, 1'b0);
        chk("R8 flag 7 releases", releasing, 1);
        run_ticks(28);
        chk("R8 flag 7 stops", voice_active, 0);

        // R6 written loop address is not replaced; R7 jump
        wr_addr(2'd2, 16'h0200);
        do_key_on();
        respond(8'h04, 1'b0);
        run_to_fetch(n);
        chk("R5 next block", mem_addr, 22'h000108);
        respond(8'h03, 1'b0);
        chk("R7 end on loop", end_flag, 1);
        chk("R7 still active", voice_active, 1);
        run_to_fetch(n);
        chk("R6 locked loop target", mem_addr, 22'h000200);

        // R9 key-off
        do_key_on();
        respond(8'h00, 1'b0);
        key_off = 1'b1;
        @(negedge clk);
        key_off = 1'b0;
        chk("R9 releasing", releasing, 1);
        chk("R9 active", voice_active, 1);
        run_to_fetch(n);
        chk("R9 fetch continues", mem_addr, 22'h000108);

        // R13 high half and R4 clamp
        wr_addr(2'd1, 16'h0001);
        wr_addr(2'd0, 16'h0000);
        wr_pitch(16'h4000);
        do_key_on();
        chk("R13 high half", mem_addr, 22'h010000);
        respond(8'h00, 1'b0);
        run_to_fetch(n);
        chk("R4 clamped ticks", n, 8);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule